// File: doc/BRIEF.md
# Memory-Type-Aware Ordered Write Buffer

This block sits between a processor store port and one downstream write bus. Each incoming write carries a two-bit memory type. Normal and Device writes are posted. They are acknowledged as soon as they enter a small age-ordered queue, and they are later sent downstream in an order that a pairwise ordering matrix allows. Strongly-ordered writes never enter the queue. The requester's handshake is held open until that write has been sent and its downstream completion pulse has returned.

The downstream side is a valid/ready handshake followed by a one-cycle completion pulse. Only one write is in flight at a time, so the order of issue is also the order of completion. When choosing what to issue, the selector takes a waiting Strongly-ordered write first if the matrix lets it go. Otherwise it takes the oldest eligible Device write, and otherwise the oldest Normal write.

A separate combinational guard screens instruction fetches. A fetch to a region flagged execute-never is dropped and raises a fault pulse. Any other fetch is passed on unchanged.

Back-pressure rules:
- On the request side, a Normal or Device write is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low while the queue is full.
- For a Strongly-ordered write, `req_ready` rises only in the completion cycle of that write. The requester must hold `req_valid` and the payload steady until then.
- On the bus side, the payload is held while `bus_valid` is high and `bus_ready` is low.

Top module: `mtype_wbuf`

## Requirements
- R1: After reset, `req_ready` is 1 for a non-strong kind, `bus_valid` is 0 and `xn_fault` is 0.
- R2: Kind codes are 00 Normal, 01 Device non-shareable, 10 Device shareable and 11 Strongly-ordered. A Normal or Device write is accepted whenever fewer than DEPTH writes are queued. One more write may be held on the bus port. `req_ready` is 0 while the queue is full.
- R3: While `bus_valid` is 1 and `bus_ready` is 0, the bus payload and `bus_valid` stay unchanged. After a bus handshake, `bus_valid` stays 0 until the `bus_done` pulse for that write.
- R4: Every accepted write is issued on the bus exactly once, with its address, data, strobes and kind unchanged.
- R5: A Device non-shareable write never issues before an earlier Device non-shareable or Strongly-ordered write. A Device shareable write never issues before an earlier Device shareable or Strongly-ordered write. A Strongly-ordered write never issues before any earlier Device write. Normal writes carry no constraint.
- R6: The issue choice follows a fixed priority. A waiting Strongly-ordered write goes first when it is eligible. Otherwise the oldest eligible Device write goes. Otherwise the oldest Normal write goes.
- R7: A Strongly-ordered write is not buffered. Its `req_ready` is 1 only in the cycle where `bus_done` completes that same write. Until then the requester is stalled.
- R8: When `fetch_valid` and `fetch_xn` are both 1, `xn_fault` is 1 in that same cycle and `ifetch_valid` is 0.
- R9: When `fetch_valid` is 1 and `fetch_xn` is 0, `ifetch_valid` is 1, `ifetch_addr` equals `fetch_addr` and `xn_fault` is 0. When `fetch_valid` is 0, both `ifetch_valid` and `xn_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Store request valid |
| req_ready | output | 1 | Store request accepted |
| req_addr | input | AW | Store address |
| req_data | input | DW | Store data |
| req_strb | input | DW/8 | Byte strobes |
| req_kind | input | 2 | Memory kind code |
| bus_valid | output | 1 | Downstream write valid |
| bus_ready | input | 1 | Downstream write taken |
| bus_addr | output | AW | Downstream address |
| bus_data | output | DW | Downstream data |
| bus_strb | output | DW/8 | Downstream strobes |
| bus_kind | output | 2 | Kind of the issued write |
| bus_done | input | 1 | Completion pulse for the write in flight |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | AW | Fetch address |
| fetch_xn | input | 1 | Target region is execute-never |
| ifetch_valid | output | 1 | Forwarded fetch strobe |
| ifetch_addr | output | AW | Forwarded fetch address |
| xn_fault | output | 1 | Execute-never fault pulse |

## Verification
The bench builds the block with its default parameters: DEPTH of 4 and 32-bit address and data. With only four slots, a short stall on the bus fills the queue. That brings within reach the full-queue back-pressure and a Strongly-ordered write stalled behind any mix of the other three kinds. It also makes the reordering choices among Normal, shareable and non-shareable Device entries occur constantly under random traffic.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

  typedef enum logic [1:0] {
    MT_NORMAL = 2'b00,
    MT_DEV_NS = 2'b01,
    MT_DEV_SH = 2'b10,
    MT_STRONG = 2'b11
  } mtype_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SEND = 2'b01,
    ST_WAIT = 2'b10
  } bstate_e;

  // 1 when a write of kind 'later' may not be issued ahead of an older 'earlier'
  function automatic logic must_follow(input mtype_e later, input mtype_e earlier);
    logic r;
    case (later)
      MT_DEV_NS: r = (earlier == MT_DEV_NS) || (earlier == MT_STRONG);
      MT_DEV_SH: r = (earlier == MT_DEV_SH) || (earlier == MT_STRONG);
      MT_STRONG: r = (earlier != MT_NORMAL);
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic is_device(input mtype_e t);
    return (t == MT_DEV_NS) || (t == MT_DEV_SH);
  endfunction

endpackage

// File: rtl/mwb_queue.sv
module mwb_queue
  import mwb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int SW   = DW / 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [AW-1:0]   push_addr,
  input  logic [DW-1:0]   push_data,
  input  logic [SW-1:0]   push_strb,
  input  mtype_e          push_type,
  input  logic            pop,
  input  logic [IW-1:0]   pop_idx,
  output logic [DEPTH-1:0] q_vld,
  output logic [AW-1:0]   q_addr [DEPTH],
  output logic [DW-1:0]   q_data [DEPTH],
  output logic [SW-1:0]   q_strb [DEPTH],
  output mtype_e          q_type [DEPTH],
  output logic            full
);

  localparam logic [IW:0] FULL_CNT = (IW+1)'(DEPTH);

  logic [IW:0] cnt;
  logic [IW:0] cnt_after;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) cnt = cnt + (IW+1)'(q_vld[i]);
  end

  assign cnt_after = cnt - (IW+1)'(pop);
  assign full      = (cnt == FULL_CNT);

  // Slot 0 is the oldest; removal shifts every younger slot down by one.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic          v_q;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;
    logic [SW-1:0] s_q;
    mtype_e        t_q;
    logic          shift;
    logic          take_new;
    logic          nv;
    logic [AW-1:0] na;
    logic [DW-1:0] nd;
    logic [SW-1:0] ns;
    mtype_e        nt;

    assign shift    = pop && (IW'(g) >= pop_idx);
    assign take_new = push && (cnt_after == (IW+1)'(g));

    if (g == DEPTH - 1) begin : g_last
      assign nv = shift ? 1'b0 : v_q;
      assign na = a_q;
      assign nd = d_q;
      assign ns = s_q;
      assign nt = t_q;
    end else begin : g_mid
      assign nv = shift ? q_vld[g+1]  : v_q;
      assign na = shift ? q_addr[g+1] : a_q;
      assign nd = shift ? q_data[g+1] : d_q;
      assign ns = shift ? q_strb[g+1] : s_q;
      assign nt = shift ? q_type[g+1] : t_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        a_q <= '0;
        d_q <= '0;
        s_q <= '0;
        t_q <= MT_NORMAL;
      end else if (take_new) begin
        v_q <= 1'b1;
        a_q <= push_addr;
        d_q <= push_data;
        s_q <= push_strb;
        t_q <= push_type;
      end else begin
        v_q <= nv;
        a_q <= na;
        d_q <= nd;
        s_q <= ns;
        t_q <= nt;
      end
    end

    assign q_vld[g]  = v_q;
    assign q_addr[g] = a_q;
    assign q_data[g] = d_q;
    assign q_strb[g] = s_q;
    assign q_type[g] = t_q;
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R4
  pop_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> q_vld[pop_idx]);

  // R4
  packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_vld + 1'b1) & q_vld) == '0);

endmodule

// File: rtl/mwb_elig.sv
module mwb_elig
  import mwb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0] q_vld,
  input  mtype_e           q_type [DEPTH],
  output logic [DEPTH-1:0] q_elig,
  output logic [DEPTH-1:0] dev_elig,
  output logic [DEPTH-1:0] nrm_elig,
  output logic             so_ok
);

  logic [DEPTH-1:0] blk [DEPTH];
  logic [DEPTH-1:0] so_blk;

  always_comb begin
    for (int g = 0; g < DEPTH; g++) begin
      for (int h = 0; h < DEPTH; h++) begin
        blk[g][h] = (h < g) && q_vld[h] && must_follow(q_type[g], q_type[h]);
      end
    end
  end

  always_comb begin
    for (int h = 0; h < DEPTH; h++) so_blk[h] = q_vld[h] && must_follow(MT_STRONG, q_type[h]);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_el
    assign q_elig[g]   = q_vld[g] && !(|blk[g]);
    assign dev_elig[g] = q_elig[g] && is_device(q_type[g]);
    assign nrm_elig[g] = q_elig[g] && (q_type[g] == MT_NORMAL);
  end

  assign so_ok = !(|so_blk);

endmodule

// File: rtl/mwb_pick.sv
module mwb_pick #(
  parameter int DEPTH = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             so_req,
  input  logic             so_ok,
  input  logic [DEPTH-1:0] dev_elig,
  input  logic [DEPTH-1:0] nrm_elig,
  output logic             pick_valid,
  output logic             pick_so,
  output logic [IW-1:0]    pick_idx
);

  logic [IW-1:0] dev_idx;
  logic [IW-1:0] nrm_idx;

  always_comb begin
    dev_idx = '0;
    nrm_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (dev_elig[i]) dev_idx = IW'(i);
      if (nrm_elig[i]) nrm_idx = IW'(i);
    end
  end

  always_comb begin
    pick_so    = so_req && so_ok;
    pick_valid = pick_so || (|dev_elig) || (|nrm_elig);
    if (|dev_elig) pick_idx = dev_idx;
    else           pick_idx = nrm_idx;
  end

endmodule

// File: rtl/mwb_xn_guard.sv
module mwb_xn_guard #(
  parameter int AW = 32
) (
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          fetch_xn,
  output logic          ifetch_valid,
  output logic [AW-1:0] ifetch_addr,
  output logic          xn_fault
);

  assign ifetch_valid = fetch_valid && !fetch_xn;
  assign ifetch_addr  = fetch_addr;
  assign xn_fault     = fetch_valid && fetch_xn;

endmodule

// File: rtl/mtype_wbuf.sv
module mtype_wbuf
  import mwb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int SW   = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [SW-1:0] req_strb,
  input  logic [1:0]    req_kind,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic [SW-1:0] bus_strb,
  output logic [1:0]    bus_kind,
  input  logic          bus_done,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          fetch_xn,
  output logic          ifetch_valid,
  output logic [AW-1:0] ifetch_addr,
  output logic          xn_fault
);

  localparam int IW = $clog2(DEPTH);

  mtype_e           req_t;
  logic             req_is_so;
  logic             so_taken_q;
  logic             cur_so_q;
  bstate_e          st_q;
  logic             push;
  logic             pop;
  logic             full;
  logic             so_req;
  logic             pick_valid;
  logic             pick_so;
  logic [IW-1:0]    pick_idx;
  logic             load;
  logic [DEPTH-1:0] q_vld;
  logic [AW-1:0]    q_addr [DEPTH];
  logic [DW-1:0]    q_data [DEPTH];
  logic [SW-1:0]    q_strb [DEPTH];
  mtype_e           q_type [DEPTH];
  logic [DEPTH-1:0] q_elig;
  logic [DEPTH-1:0] dev_elig;
  logic [DEPTH-1:0] nrm_elig;
  logic             so_ok;
  logic [AW-1:0]    o_addr_q;
  logic [DW-1:0]    o_data_q;
  logic [SW-1:0]    o_strb_q;
  mtype_e           o_type_q;

  assign req_t     = mtype_e'(req_kind);
  assign req_is_so = (req_t == MT_STRONG);

  // Posted kinds see queue space; a strong write sees its own completion.
  assign req_ready = req_is_so ? ((st_q == ST_WAIT) && cur_so_q && bus_done) : !full;
  assign push      = req_valid && !req_is_so && !full;
  assign so_req    = req_valid && req_is_so && !so_taken_q;
  assign load      = (st_q == ST_IDLE) && pick_valid;
  assign pop       = load && !pick_so;

  mwb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (req_addr),
    .push_data (req_data),
    .push_strb (req_strb),
    .push_type (req_t),
    .pop       (pop),
    .pop_idx   (pick_idx),
    .q_vld     (q_vld),
    .q_addr    (q_addr),
    .q_data    (q_data),
    .q_strb    (q_strb),
    .q_type    (q_type),
    .full      (full)
  );

  mwb_elig #(.DEPTH(DEPTH)) u_elig (
    .q_vld    (q_vld),
    .q_type   (q_type),
    .q_elig   (q_elig),
    .dev_elig (dev_elig),
    .nrm_elig (nrm_elig),
    .so_ok    (so_ok)
  );

  mwb_pick #(.DEPTH(DEPTH)) u_pick (
    .so_req     (so_req),
    .so_ok      (so_ok),
    .dev_elig   (dev_elig),
    .nrm_elig   (nrm_elig),
    .pick_valid (pick_valid),
    .pick_so    (pick_so),
    .pick_idx   (pick_idx)
  );

  mwb_xn_guard #(.AW(AW)) u_xn (
    .fetch_valid  (fetch_valid),
    .fetch_addr   (fetch_addr),
    .fetch_xn     (fetch_xn),
    .ifetch_valid (ifetch_valid),
    .ifetch_addr  (ifetch_addr),
    .xn_fault     (xn_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cur_so_q <= 1'b0;
      o_addr_q <= '0;
      o_data_q <= '0;
      o_strb_q <= '0;
      o_type_q <= MT_NORMAL;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (pick_valid) begin
            st_q     <= ST_SEND;
            cur_so_q <= pick_so;
            if (pick_so) begin
              o_addr_q <= req_addr;
              o_data_q <= req_data;
              o_strb_q <= req_strb;
              o_type_q <= req_t;
            end else begin
              o_addr_q <= q_addr[pick_idx];
              o_data_q <= q_data[pick_idx];
              o_strb_q <= q_strb[pick_idx];
              o_type_q <= q_type[pick_idx];
            end
          end
        end
        ST_SEND: begin
          if (bus_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (bus_done) begin
            st_q     <= ST_IDLE;
            cur_so_q <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 so_taken_q <= 1'b0;
    else if (load && pick_so)                   so_taken_q <= 1'b1;
    else if (req_valid && req_ready && req_is_so) so_taken_q <= 1'b0;
  end

  assign bus_valid = (st_q == ST_SEND);
  assign bus_addr  = o_addr_q;
  assign bus_data  = o_data_q;
  assign bus_strb  = o_strb_q;
  assign bus_kind  = o_type_q;

  logic dev_free;
  always_comb begin
    dev_free = 1'b1;
    for (int i = 0; i < DEPTH; i++) if (q_vld[i] && (q_type[i] != MT_NORMAL)) dev_free = 1'b0;
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data)
                                && $stable(bus_strb) && $stable(bus_kind));

  // R3
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready |=> !bus_valid);

  // R7
  so_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_kind == 2'b11) |-> bus_done && !bus_valid);

  // R5
  so_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && pick_so |-> dev_free);

  // R5
  q_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> q_elig[pick_idx]);

  // R8
  xn_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_xn |-> xn_fault && !ifetch_valid);

endmodule

// File: tb/test_mtype_wbuf.sv
module test_mtype_wbuf;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int SW = DW / 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [SW-1:0] req_strb;
  logic [1:0]    req_kind;
  logic          bus_valid;
  logic          bus_ready;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic [SW-1:0] bus_strb;
  logic [1:0]    bus_kind;
  logic          bus_done;
  logic          fetch_valid;
  logic [AW-1:0] fetch_addr;
  logic          fetch_xn;
  logic          ifetch_valid;
  logic [AW-1:0] ifetch_addr;
  logic          xn_fault;

  mtype_wbuf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_mtype_wbuf (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_strb(req_strb), .req_kind(req_kind),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_strb(bus_strb), .bus_kind(bus_kind), .bus_done(bus_done),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_xn(fetch_xn),
    .ifetch_valid(ifetch_valid), .ifetch_addr(ifetch_addr), .xn_fault(xn_fault)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pending source of requests and model of accepted-but-unissued writes
  logic [AW-1:0] s_addr[$];
  logic [DW-1:0] s_data[$];
  logic [SW-1:0] s_strb[$];
  logic [1:0]    s_kind[$];
  logic [AW-1:0] p_addr[$];
  logic [DW-1:0] p_data[$];
  logic [SW-1:0] p_strb[$];
  logic [1:0]    p_kind[$];
  logic [DW-1:0] iss_log[$];

  bit ds_hold = 1'b0;
  bit dn_wait = 1'b0;
  int dn_cnt = 0;
  bit acc_last = 1'b0;
  int acc_cnt = 0;
  bit hold_prev = 1'b0;
  logic [AW+DW+SW+1:0] hold_pay;
  int seq = 0;

  // ordering table from the requirements: kind codes 00 N, 01 DNS, 10 DS, 11 SO
  function automatic bit ord_req(input logic [1:0] later, input logic [1:0] earlier);
    case (later)
      2'b01:   return (earlier == 2'b01) || (earlier == 2'b11);
      2'b10:   return (earlier == 2'b10) || (earlier == 2'b11);
      2'b11:   return (earlier == 2'b01) || (earlier == 2'b10) || (earlier == 2'b11);
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit in_pending(input logic [DW-1:0] d);
    foreach (p_data[i]) if (p_data[i] == d) return 1'b1;
    return 1'b0;
  endfunction

  task automatic enqueue(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [SW-1:0] s, input logic [1:0] k);
    s_addr.push_back(a);
    s_data.push_back(d);
    s_strb.push_back(s);
    s_kind.push_back(k);
  endtask

  task automatic issue_check();
    int k = -1;
    bit bad = 1'b0;
    foreach (p_data[i]) if (k < 0 && p_data[i] == bus_data) k = i;
    check(k >= 0, "R4 issued write not pending", longint'(bus_data), 0);
    if (k >= 0) begin
      check(p_addr[k] == bus_addr && p_strb[k] == bus_strb && p_kind[k] == bus_kind,
            "R4 issued payload", longint'({bus_kind, bus_strb, bus_addr}),
            longint'({p_kind[k], p_strb[k], p_addr[k]}));
      for (int j = 0; j < k; j++) if (ord_req(p_kind[k], p_kind[j])) bad = 1'b1;
      check(!bad, "R5 ordering violated", k, 0);
      p_addr.delete(k);
      p_data.delete(k);
      p_strb.delete(k);
      p_kind.delete(k);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (acc_last) begin
      req_valid = 1'b0;
      acc_last = 1'b0;
    end
    bus_done = 1'b0;
    if (dn_wait) begin
      if (dn_cnt == 0) bus_done = 1'b1;
      else dn_cnt--;
    end
    bus_ready = ds_hold ? 1'b0 : ($urandom_range(3) != 0);
    if (!req_valid && s_addr.size() > 0) begin
      req_valid = 1'b1;
      req_addr = s_addr.pop_front();
      req_data = s_data.pop_front();
      req_strb = s_strb.pop_front();
      req_kind = s_kind.pop_front();
      if (req_kind == 2'b11) begin
        p_addr.push_back(req_addr);
        p_data.push_back(req_data);
        p_strb.push_back(req_strb);
        p_kind.push_back(req_kind);
      end
    end
    fetch_valid = $urandom_range(1);
    fetch_xn = $urandom_range(1);
    fetch_addr = $urandom;
    #1;
    if (fetch_valid && fetch_xn)
      check(xn_fault && !ifetch_valid, "R8 xn fetch blocked", {xn_fault, ifetch_valid}, 2'b10);
    else if (fetch_valid)
      check(!xn_fault && ifetch_valid && ifetch_addr == fetch_addr, "R9 fetch forwarded",
            {xn_fault, ifetch_valid}, 2'b01);
    else
      check(!xn_fault && !ifetch_valid, "R9 idle fetch", {xn_fault, ifetch_valid}, 2'b00);
    if (hold_prev)
      check(bus_valid && {bus_kind, bus_strb, bus_data, bus_addr} == hold_pay,
            "R3 payload held", longint'(bus_data), longint'(hold_pay[AW+DW-1:AW]));
    if (req_valid && req_ready) begin
      acc_cnt++;
      acc_last = 1'b1;
      if (req_kind == 2'b11) begin
        check(bus_done == 1'b1, "R7 strong ack without completion", bus_done, 1);
        check(!in_pending(req_data), "R7 strong acked before issue", 1, 0);
      end else begin
        p_addr.push_back(req_addr);
        p_data.push_back(req_data);
        p_strb.push_back(req_strb);
        p_kind.push_back(req_kind);
      end
    end
    if (dn_wait && !bus_done && bus_valid)
      check(1'b0, "R3 second write while one in flight", 1, 0);
    if (bus_done) dn_wait = 1'b0;
    if (bus_valid && bus_ready) begin
      issue_check();
      iss_log.push_back(bus_data);
      dn_wait = 1'b1;
      dn_cnt = $urandom_range(2);
    end
    hold_prev = bus_valid && !bus_ready;
    hold_pay = {bus_kind, bus_strb, bus_data, bus_addr};
  endtask

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      if (s_addr.size() == 0 && p_data.size() == 0 && !req_valid && !dn_wait) break;
      step();
    end
  endtask

  task automatic order_case(input string tag, input logic [1:0] kinds[5], input int n,
                            input int exp_order[5]);
    iss_log.delete();
    ds_hold = 1'b1;
    for (int i = 0; i < n; i++) enqueue(32'h100 + i * 4, 32'hA000_0000 + i, 4'hF, kinds[i]);
    for (int i = 0; i < 14; i++) step();
    if (kinds[n-1] == 2'b11)
      check(req_valid && !req_ready, "R7 strong write stalled", req_ready, 0);
    ds_hold = 1'b0;
    drain();
    check(iss_log.size() == n, {tag, " issue count"}, iss_log.size(), n);
    for (int i = 0; i < n; i++)
      if (i < iss_log.size())
        check(iss_log[i] == 32'hA000_0000 + exp_order[i], tag, longint'(iss_log[i]),
              longint'(32'hA000_0000 + exp_order[i]));
  endtask

  initial begin
    #(4 * 180000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] kd[5];
    int eo[5];
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_data = '0; req_strb = '0; req_kind = 2'b00;
    bus_ready = 1'b0; bus_done = 1'b0;
    fetch_valid = 1'b0; fetch_addr = '0; fetch_xn = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(bus_valid == 1'b0, "R1 bus idle after reset", bus_valid, 0);
    check(xn_fault == 1'b0, "R1 no fault after reset", xn_fault, 0);

    // R2: capacity is DEPTH queued plus one on the bus port
    iss_log.delete();
    ds_hold = 1'b1;
    acc_cnt = 0;
    for (int i = 0; i < 6; i++) enqueue(32'h40 + i * 4, 32'hA000_0000 + i, 4'h3, 2'b00);
    for (int i = 0; i < 14; i++) step();
    check(acc_cnt == DEPTH + 1, "R2 accepted before full", acc_cnt, DEPTH + 1);
    check(req_valid && !req_ready, "R2 ready low when full", req_ready, 0);
    ds_hold = 1'b0;
    drain();
    for (int i = 0; i < 6; i++)
      if (i < iss_log.size())
        check(iss_log[i] == 32'hA000_0000 + i, "R6 normals oldest first",
              longint'(iss_log[i]), longint'(32'hA000_0000 + i));

    // R6: Device first, oldest eligible; Normals after
    kd = '{2'b00, 2'b00, 2'b01, 2'b10, 2'b00};
    eo = '{0, 2, 3, 1, 4};
    order_case("R6 device priority", kd, 5, eo);

    // R7 / R6: strong write passes queued Normals
    kd = '{2'b00, 2'b00, 2'b00, 2'b11, 2'b00};
    eo = '{0, 3, 1, 2, 0};
    order_case("R7 strong passes normals", kd, 4, eo);

    // R5: strong write waits for an earlier Device write
    kd = '{2'b00, 2'b10, 2'b00, 2'b11, 2'b00};
    eo = '{0, 1, 3, 2, 0};
    order_case("R5 strong after device", kd, 4, eo);

    // random traffic mixed with bus stalls
    for (int c = 0; c < 5000; c++) begin
      int r;
      logic [1:0] k;
      ds_hold = (c % 250) < 40;
      if (s_addr.size() == 0 && $urandom_range(2) != 0) begin
        r = $urandom_range(9);
        k = (r < 4 || r == 9) ? 2'b00 : (r < 6) ? 2'b01 : (r < 8) ? 2'b10 : 2'b11;
        seq++;
        enqueue($urandom, 32'h1000_0000 + seq, 4'($urandom_range(15, 1)), k);
      end
      step();
    end
    ds_hold = 1'b0;
    drain();
    check(p_data.size() == 0, "R4 all accepted writes issued", p_data.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule